// File: doc/BRIEF.md
# Programmable Maximum On-Time Clamp

This block is a fault-protection timer for one bidirectional flyback cell balancer. When a cell is discharged, the primary winding's switch conducts. When a cell is charged, the secondary winding's switch conducts. In normal operation a phase ends when the winding current reaches its threshold. If the current-sense element is shorted, that threshold never arrives and the current would ramp without bound. This block bounds the phase. It counts clock cycles while a switch is enabled and forces the switch off once the count reaches a programmed limit.

The two directions have their own limit words, and each side's clamp can be defeated on its own. A phase starts on the rising edge of a side's request and ends on the first of four events: the current-threshold flag, the request being released, a conflict with the other side's request, or a timeout. A one-cycle event pulse marks the phases that were ended by timeout. Converting an analog setting into a cycle count, the gate drivers and the current sensing all lie outside the block.

Top module: `ontime_clamp`

## Requirements
- R1: While `rst_n` is low, `pri_en`, `sec_en` and `clamp_evt` are all low.
- R2: A rising edge of `pri_req` while `sec_req` is low sets `pri_en` high from the next clock edge.
- R3: A rising edge of `sec_req` while `pri_req` is low sets `sec_en` high from the next clock edge.
- R4: With its clamp enabled and no other ending event, an enable stays high for exactly N cycles, where N is that side's limit word, and for one cycle when the limit is 0.
- R5: When a timeout ends a phase, `clamp_evt` is high for exactly one cycle, which is the first cycle in which that enable is low.
- R6: `ilim_hit` sampled high while an enable is high drives that enable low at the next edge without a `clamp_evt` pulse. This also holds when the threshold arrives in the same cycle as the timeout.
- R7: Releasing the request ends its phase at the next edge without a `clamp_evt` pulse.
- R8: When a side's clamp-disable bit is high, that side's enable never times out and raises no `clamp_evt`. The other side keeps its own clamp.
- R9: When `pri_req` and `sec_req` are both high, both enables are low from the next edge, and neither side starts.
- R10: After a phase ends, its side starts again only on a new rising edge of its request. Holding the request high does not restart it.
- R11: The primary phase is timed only by `pri_limit` and the secondary phase only by `sec_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_req | input | 1 | Request to conduct on the primary (discharge) side |
| sec_req | input | 1 | Request to conduct on the secondary (charge) side |
| ilim_hit | input | 1 | Winding current has reached its turn-off threshold |
| pri_limit | input | CNT_W | Maximum primary on-time in clock cycles |
| sec_limit | input | CNT_W | Maximum secondary on-time in clock cycles |
| pri_clamp_dis | input | 1 | Disable the primary on-time clamp |
| sec_clamp_dis | input | 1 | Disable the secondary on-time clamp |
| pri_en | output | 1 | Gated primary switch enable |
| sec_en | output | 1 | Gated secondary switch enable |
| clamp_evt | output | 1 | One-cycle pulse when a phase was ended by timeout |

## Verification
Directed phases on each side run with the request held past the limit. They measure the enable length and count the event pulses, which separates a correct limit from one that is off by one and shows whether the wrong side's limit word is being used. A threshold that arrives in the same cycle as the timeout separates the two ways a phase can end. A clamp-disabled run with a tiny limit shows that the timeout is actually suppressed. Requests that start together, and requests held high after a phase has ended, exercise the conflict and restart rules. After that, random requests, thresholds, limits and disable bits are compared cycle by cycle against a bench model of the requirements.

// File: rtl/ontime_clamp_pkg.sv
package ontime_clamp_pkg;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_PRI  = 0;
    localparam int SIDE_SEC  = 1;
endpackage

// File: rtl/otc_side_timer.sv
module otc_side_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rival_req,
    input  logic             ilim_hit,
    input  logic [CNT_W-1:0] limit,
    input  logic             clamp_dis,
    output logic             en,
    output logic             timeout_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             req_prev;
        logic             en;
        logic             evt;
        logic [CNT_W-1:0] cnt;
    } side_st_t;

    side_st_t st_d, st_q;

    logic start_edge, soft_stop, expired;

    always_comb begin
        start_edge = req && !st_q.req_prev && !rival_req;
        soft_stop  = !req || rival_req || ilim_hit;
        expired    = !clamp_dis && (st_q.cnt >= limit);

        st_d          = st_q;
        st_d.req_prev = req;
        st_d.evt      = 1'b0;
        if (st_q.en) begin
            if (soft_stop) begin
                st_d.en  = 1'b0;
                st_d.cnt = '0;
            end else if (expired) begin
                st_d.en  = 1'b0;
                st_d.cnt = '0;
                st_d.evt = 1'b1;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end else if (start_edge) begin
            st_d.en  = 1'b1;
            st_d.cnt = CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en            = st_q.en;
    assign timeout_pulse = st_q.evt;
endmodule

// File: rtl/otc_evt_merge.sv
module otc_evt_merge #(
    parameter int N = 2
) (
    input  logic [N-1:0] evt_in,
    output logic         evt_out
);
    assign evt_out = |evt_in;
endmodule

// File: rtl/ontime_clamp.sv
module ontime_clamp
    import ontime_clamp_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_req,
    input  logic             sec_req,
    input  logic             ilim_hit,
    input  logic [CNT_W-1:0] pri_limit,
    input  logic [CNT_W-1:0] sec_limit,
    input  logic             pri_clamp_dis,
    input  logic             sec_clamp_dis,
    output logic             pri_en,
    output logic             sec_en,
    output logic             clamp_evt
);
    logic [NUM_SIDES-1:0]            req_v, dis_v, en_v, evt_v;
    logic [NUM_SIDES-1:0][CNT_W-1:0] lim_v;

    assign req_v[SIDE_PRI] = pri_req;
    assign req_v[SIDE_SEC] = sec_req;
    assign dis_v[SIDE_PRI] = pri_clamp_dis;
    assign dis_v[SIDE_SEC] = sec_clamp_dis;
    assign lim_v[SIDE_PRI] = pri_limit;
    assign lim_v[SIDE_SEC] = sec_limit;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        otc_side_timer #(.CNT_W(CNT_W)) u_timer (
            .clk          (clk),
            .rst_n        (rst_n),
            .req          (req_v[s]),
            .rival_req    (req_v[NUM_SIDES-1-s]),
            .ilim_hit     (ilim_hit),
            .limit        (lim_v[s]),
            .clamp_dis    (dis_v[s]),
            .en           (en_v[s]),
            .timeout_pulse(evt_v[s])
        );
    end

    otc_evt_merge #(.N(NUM_SIDES)) u_merge (
        .evt_in (evt_v),
        .evt_out(clamp_evt)
    );

    assign pri_en = en_v[SIDE_PRI];
    assign sec_en = en_v[SIDE_SEC];
endmodule

// File: rtl/ontime_clamp_chk.sv
module ontime_clamp_chk (
    input logic clk,
    input logic rst_n,
    input logic pri_req,
    input logic sec_req,
    input logic ilim_hit,
    input logic pri_clamp_dis,
    input logic sec_clamp_dis,
    input logic pri_en,
    input logic sec_en,
    input logic clamp_evt
);
    // R9
    exclusive_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_en && sec_en));
    // R9
    conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_req && sec_req) |=> (!pri_en && !sec_en));
    // R5
    evt_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_evt |-> ($fell(pri_en) || $fell(sec_en)));
    // R5
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_evt |=> !clamp_evt);
    // R6
    pri_ilim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_en && ilim_hit) |=> (!pri_en && !clamp_evt));
    // R6
    sec_ilim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_en && ilim_hit) |=> (!sec_en && !clamp_evt));
    // R7
    pri_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_req |=> !pri_en);
    // R7
    sec_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_req |=> !sec_en);
    // R8
    pri_nodis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_en && pri_clamp_dis) |=> !clamp_evt);
    // R8
    sec_nodis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_en && sec_clamp_dis) |=> !clamp_evt);
    // R10
    pri_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_en && $past(pri_req)) |=> !pri_en);
endmodule

bind ontime_clamp ontime_clamp_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pri_req      (pri_req),
    .sec_req      (sec_req),
    .ilim_hit     (ilim_hit),
    .pri_clamp_dis(pri_clamp_dis),
    .sec_clamp_dis(sec_clamp_dis),
    .pri_en       (pri_en),
    .sec_en       (sec_en),
    .clamp_evt    (clamp_evt)
);

// File: tb/sim_ontime_clamp.sv
`timescale 1ns/1ps
module sim_ontime_clamp;
    localparam int CNT_W = 10;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_req = 1'b0, sec_req = 1'b0, ilim_hit = 1'b0;
    logic [CNT_W-1:0] pri_limit = '0, sec_limit = '0;
    logic pri_clamp_dis = 1'b0, sec_clamp_dis = 1'b0;
    logic pri_en, sec_en, clamp_evt;

    int checks = 0, failures = 0;
    int n_pri = 0, n_sec = 0, n_evt = 0;
    bit finished = 0;

    logic m_prev[2], m_en[2];
    int   m_cnt[2];
    logic m_evt;

    always #2 clk = ~clk;

    ontime_clamp #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pri_req(pri_req), .sec_req(sec_req),
        .ilim_hit(ilim_hit), .pri_limit(pri_limit), .sec_limit(sec_limit),
        .pri_clamp_dis(pri_clamp_dis), .sec_clamp_dis(sec_clamp_dis),
        .pri_en(pri_en), .sec_en(sec_en), .clamp_evt(clamp_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_step();
        logic ev = 1'b0;
        for (int s = 0; s < 2; s++) begin
            logic req = (s == 0) ? pri_req : sec_req;
            logic oth = (s == 0) ? sec_req : pri_req;
            int   lim = (s == 0) ? int'(pri_limit) : int'(sec_limit);
            logic dis = (s == 0) ? pri_clamp_dis : sec_clamp_dis;
            if (m_en[s]) begin
                if (!req || oth || ilim_hit) begin
                    m_en[s] = 1'b0; m_cnt[s] = 0;
                end else if (!dis && m_cnt[s] >= lim) begin
                    m_en[s] = 1'b0; m_cnt[s] = 0; ev = 1'b1;
                end else if (m_cnt[s] < CMAX) begin
                    m_cnt[s] = m_cnt[s] + 1;
                end
            end else if (req && !m_prev[s] && !oth) begin
                m_en[s] = 1'b1; m_cnt[s] = 1;
            end
            m_prev[s] = req;
        end
        m_evt = ev;
    endfunction

    // inputs are already set; advance one clock and compare at the following negedge
    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        chk({tag, " pri_en"}, int'(pri_en), int'(m_en[0]));
        chk({tag, " sec_en"}, int'(sec_en), int'(m_en[1]));
        chk({tag, " clamp_evt"}, int'(clamp_evt), int'(m_evt));
        if (pri_en) n_pri++;
        if (sec_en) n_sec++;
        if (clamp_evt) n_evt++;
    endtask

    task automatic idle(input string tag);
        pri_req = 0; sec_req = 0; ilim_hit = 0;
        repeat (2) tick(tag);
        n_pri = 0; n_sec = 0; n_evt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int s = 0; s < 2; s++) begin m_prev[s] = 0; m_en[s] = 0; m_cnt[s] = 0; end
        m_evt = 0;
        pri_req = 1; sec_req = 0;
        repeat (3) @(negedge clk);
        // R1: outputs low in reset even with a request present
        chk("R1 pri_en", int'(pri_en), 0);
        chk("R1 sec_en", int'(sec_en), 0);
        chk("R1 clamp_evt", int'(clamp_evt), 0);
        pri_req = 0;
        @(negedge clk);
        rst_n = 1;
        idle("R1");

        // R2 R4 R5 R10: primary timeout, request held past it
        pri_limit = 5; sec_limit = 40;
        pri_req = 1;
        repeat (12) tick("R2");
        chk("R4 primary length", n_pri, 5);
        chk("R5 event count", n_evt, 1);
        chk("R10 no restart", int'(pri_en), 0);
        idle("R10");

        // R3 R11: secondary uses its own limit
        pri_limit = 50; sec_limit = 3;
        sec_req = 1;
        repeat (8) tick("R3");
        chk("R11 secondary length", n_sec, 3);
        chk("R11 event count", n_evt, 1);
        idle("R11");

        // R4: limit 0 behaves as one cycle
        pri_limit = 0; pri_req = 1;
        repeat (4) tick("R4");
        chk("R4 zero limit length", n_pri, 1);
        idle("R4");

        // R8: primary clamp disabled, secondary still clamped
        pri_limit = 2; pri_clamp_dis = 1; pri_req = 1;
        repeat (20) tick("R8");
        chk("R8 primary held", n_pri, 20);
        chk("R8 no event", n_evt, 0);
        idle("R8");
        sec_limit = 2; sec_req = 1;
        repeat (5) tick("R8");
        chk("R8 secondary still clamped", n_sec, 2);
        pri_clamp_dis = 0;
        idle("R8");

        // R6: threshold in the same cycle as the timeout
        pri_limit = 4; pri_req = 1;
        tick("R6");
        while (n_pri < 4) tick("R6");
        ilim_hit = 1;
        tick("R6");
        ilim_hit = 0;
        repeat (3) tick("R6");
        chk("R6 length", n_pri, 4);
        chk("R6 no event", n_evt, 0);
        idle("R6");

        // R7: release before limit
        pri_limit = 30; pri_req = 1;
        repeat (3) tick("R7");
        pri_req = 0;
        repeat (3) tick("R7");
        chk("R7 length", n_pri, 3);
        chk("R7 no event", n_evt, 0);
        idle("R7");

        // R9: both requests rise together, then one dropped
        pri_req = 1; sec_req = 1;
        repeat (3) tick("R9");
        sec_req = 0;
        repeat (3) tick("R9");
        chk("R9 no start", n_pri + n_sec, 0);
        idle("R9");

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) pri_req = ~pri_req;
            if ($urandom_range(0, 7) == 0) sec_req = ~sec_req;
            ilim_hit = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 40) == 0) begin
                pri_limit = CNT_W'($urandom_range(0, 12));
                sec_limit = CNT_W'($urandom_range(0, 12));
                pri_clamp_dis = ($urandom_range(0, 4) == 0);
                sec_clamp_dis = ($urandom_range(0, 4) == 0);
            end
            tick("R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule